// File: doc/BRIEF.md
# Pipelined Multi-Operand Complex Adder-Subtractor

This block forms a signed sum of `N_IN` complex operands. Each operand is given a fixed sign at build time: it is either added or subtracted. The real parts and the imaginary parts go through two identical trees of two-input nodes. Both trees use the same sign pattern and the same control. The first level of each tree pairs neighbouring ports. Each later level adds the results of the level below, and a node with no partner passes its operand through. The result has full precision, `W_IN + clog2(N_IN)` bits, so it cannot overflow.

When `PIPELINED` is set, every tree level has a register. The latency is then `clog2(N_IN)` load cycles. A repeating phase mask of length `PH_LEN` selects the cycles in which the stage registers load. An optional clock enable (`USE_EN`) stops both the registers and the phase counter. An optional asynchronous active-low clear (`USE_CLR`) zeroes the registers and the phase counter. When `PIPELINED` is clear, the result is purely combinational.

If a first-level pair has both of its operands subtracted, the sign pattern is illegal and elaboration is stopped.

Top module: `cpx_addsub`

## Requirements
- R1: Port i occupies bits [i*W_IN +: W_IN] of `re_in`/`im_in` as a two's complement value. Bit i of `SUB_MASK` set to 1 subtracts port i and 0 adds it. The output is the exact signed sum in W_IN+clog2(N_IN) bits, including at the extreme input values.
- R2: Ports above the width of the `SUB_MASK` literal given are added. A subtracted first operand of a node produces -x + y.
- R3: A pattern in which two subtractions are adjacent across a pair boundary (ports 1 and 2 of ports 0..4) is legal and computes correctly. A pair whose two operands are both subtracted stops elaboration.
- R4: The real and imaginary results are independent of each other's inputs.
- R5: With pipelining on and a mask of all ones, an input applied before clock edge k appears at the output after edge k+clog2(N_IN)-1. A new result appears every cycle.
- R6: Mask bit p (the LSB is phase 0) enables loading in phase p. The phase counter is 0 after clear, advances once per enabled cycle and wraps after PH_LEN-1. The registers load only in phases whose bit is 1.
- R7: With USE_EN=1 and `en` low, the outputs and the phase counter hold.
- R8: With USE_EN=0, the level of `en` has no effect.
- R9: `rst_n` low zeroes the outputs of a pipelined instance at once, without a clock edge, and returns the phase counter to phase 0.
- R10: With PIPELINED=0, the output follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear (used when USE_CLR=1) |
| en | input | 1 | Clock enable for the stage registers and the phase counter (used when USE_EN=1) |
| re_in | input | N_IN*W_IN | Real parts, port i at [i*W_IN +: W_IN] |
| im_in | input | N_IN*W_IN | Imaginary parts, same layout as re_in |
| re_out | output | W_IN+clog2(N_IN) | Real part of the result |
| im_out | output | W_IN+clog2(N_IN) | Imaginary part of the result |

## Verification
A wrong sign or pairing in a node shows up as a wrong sum within clog2(N_IN) load cycles. A phase counter that is misaligned or wraps at the wrong count shifts the instant at which a new input reaches the output. The bench therefore predicts, cycle by cycle, the edge at which the output must switch, and compares against that. An enable or clear that leaks shows up in the first cycle after it is applied, either as an output that moves while it should hold or as a nonzero value during clear.

// File: rtl/cas_pkg.sv
package cas_pkg;

  // number of values present at tree level l for n leaves
  function automatic int lvl_cnt(int n, int l);
    return (n + (1 << l) - 1) >> l;
  endfunction

  // true when a first-level pair has both operands subtracted
  function automatic bit pair_bad(int n, logic [63:0] sub);
    bit bad = 1'b0;
    for (int i = 0; 2 * i + 1 < n; i++) begin
      if (sub[2*i] && sub[2*i+1]) bad = 1'b1;
    end
    return bad;
  endfunction

endpackage

// File: rtl/cas_node.sv
module cas_node #(
  parameter int W     = 8,
  parameter bit NEG_A = 1'b0,
  parameter bit NEG_B = 1'b0,
  parameter bit PIPE  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);

  logic signed [W-1:0] opa, opb, sum;

  always_comb begin
    opa = NEG_A ? -a : a;
    opb = NEG_B ? -b : b;
    sum = opa + opb;
  end

  generate
    if (PIPE) begin : g_reg
      logic signed [W-1:0] q, q_nxt;

      always_comb q_nxt = ld ? sum : q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
      end

      assign y = q;

      // R7
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));
    end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_n, ld};
      assign y = sum;
    end
  endgenerate

endmodule

// File: rtl/cas_phase.sv
module cas_phase #(
  parameter int                PH_LEN  = 1,
  parameter logic [PH_LEN-1:0] PH_MASK = '1,
  parameter bit                USE_EN  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic cap
);

  localparam int CW = (PH_LEN > 1) ? $clog2(PH_LEN) : 1;
  localparam int XW = 1 << CW;
  localparam logic [XW-1:0] MASK_X = XW'(PH_MASK);

  logic          en_i;
  logic [CW-1:0] cnt, cnt_nxt;

  generate
    if (USE_EN) begin : g_en
      assign en_i = en;
    end else begin : g_noen
      logic unused_en;
      assign unused_en = en;
      assign en_i = 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_nxt = cnt;
    if (en_i) cnt_nxt = (cnt == CW'(PH_LEN - 1)) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign cap = en_i & MASK_X[cnt];

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cnt == CW'(PH_LEN - 1)) |=> (cnt == '0));

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt));

endmodule

// File: rtl/cas_tree.sv
module cas_tree
  import cas_pkg::*;
#(
  parameter int           N    = 5,
  parameter int           W_IN = 8,
  parameter logic [N-1:0] SUB  = '0,
  parameter bit           PIPE = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cap,
  input  logic [N*W_IN-1:0]                   din,
  output logic signed [W_IN+$clog2(N)-1:0]    dout
);

  localparam int LV = $clog2(N);
  localparam int WO = W_IN + LV;
  localparam logic [N:0] SUBX = {1'b0, SUB};

  logic signed [WO-1:0] val [0:LV][0:N-1];

  generate
    for (genvar i = 0; i < N; i++) begin : g_leaf
      assign val[0][i] = {{(WO-W_IN){din[i*W_IN+W_IN-1]}}, din[i*W_IN +: W_IN]};
    end

    for (genvar l = 0; l < LV; l++) begin : g_lvl
      localparam int CIN  = lvl_cnt(N, l);
      localparam int COUT = lvl_cnt(N, l + 1);
      for (genvar j = 0; j < N; j++) begin : g_slot
        if (j < COUT) begin : g_n
          localparam bit HB = (2 * j + 1 < CIN);
          localparam bit NA = (l == 0) && SUBX[2*j];
          localparam bit NB = (l == 0) && HB && SUBX[2*j+1];
          logic signed [WO-1:0] opb;
          if (HB) begin : g_pair
            assign opb = val[l][2*j+1];
          end else begin : g_lone
            assign opb = '0;
          end
          cas_node #(.W(WO), .NEG_A(NA), .NEG_B(NB), .PIPE(PIPE)) u_node (
            .clk  (clk),
            .rst_n(rst_n),
            .ld   (cap),
            .a    (val[l][2*j]),
            .b    (opb),
            .y    (val[l+1][j])
          );
        end else begin : g_z
          assign val[l+1][j] = '0;
        end
      end
    end
  endgenerate

  assign dout = val[LV][0];

endmodule

// File: rtl/cpx_addsub.sv
module cpx_addsub
  import cas_pkg::*;
#(
  parameter int                N_IN      = 5,
  parameter int                W_IN      = 8,
  parameter logic [N_IN-1:0]   SUB_MASK  = 5'b00110,
  parameter bit                PIPELINED = 1'b1,
  parameter int                PH_LEN    = 1,
  parameter logic [PH_LEN-1:0] PH_MASK   = 1'b1,
  parameter bit                USE_EN    = 1'b1,
  parameter bit                USE_CLR   = 1'b1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 en,
  input  logic [N_IN*W_IN-1:0]                 re_in,
  input  logic [N_IN*W_IN-1:0]                 im_in,
  output logic signed [W_IN+$clog2(N_IN)-1:0]  re_out,
  output logic signed [W_IN+$clog2(N_IN)-1:0]  im_out
);

  logic rst_i;
  logic cap;

  generate
    if (N_IN < 2) begin : g_bad_n
      $error("cpx_addsub: N_IN must be at least 2");
    end
    if (pair_bad(N_IN, 64'(SUB_MASK))) begin : g_bad_signs
      $error("cpx_addsub: a first-level pair subtracts both operands");
    end
    if (USE_CLR) begin : g_clr
      assign rst_i = rst_n;
    end else begin : g_noclr
      logic unused_rst;
      assign unused_rst = rst_n;
      assign rst_i = 1'b1;
    end
  endgenerate

  cas_phase #(.PH_LEN(PH_LEN), .PH_MASK(PH_MASK), .USE_EN(USE_EN)) u_phase (
    .clk  (clk),
    .rst_n(rst_i),
    .en   (en),
    .cap  (cap)
  );

  cas_tree #(.N(N_IN), .W_IN(W_IN), .SUB(SUB_MASK), .PIPE(PIPELINED)) u_re (
    .clk  (clk),
    .rst_n(rst_i),
    .cap  (cap),
    .din  (re_in),
    .dout (re_out)
  );

  cas_tree #(.N(N_IN), .W_IN(W_IN), .SUB(SUB_MASK), .PIPE(PIPELINED)) u_im (
    .clk  (clk),
    .rst_n(rst_i),
    .cap  (cap),
    .din  (im_in),
    .dout (im_out)
  );

  generate
    if (PIPELINED && USE_EN) begin : g_en_chk
      // R7
      en_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
        !en |=> ($stable(re_out) && $stable(im_out)));
    end
  endgenerate

endmodule

// File: tb/test_cpx_addsub.sv
module test_cpx_addsub;

  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  logic en;
  logic ph_en;
  logic [39:0] re_in, im_in;
  logic signed [10:0] re_out, im_out;
  logic [31:0] ph_re, ph_im;
  logic signed [9:0] ph_ro, ph_io;
  logic [23:0] cb_re, cb_im;
  logic signed [9:0] cb_ro, cb_io;

  int checks = 0;
  int fails  = 0;
  int unsigned ph_edges;

  cpx_addsub i_cpx_addsub (
    .clk(clk), .rst_n(rst_n), .en(en),
    .re_in(re_in), .im_in(im_in), .re_out(re_out), .im_out(im_out)
  );

  cpx_addsub #(.N_IN(4), .W_IN(8), .SUB_MASK(4'b0000), .PIPELINED(1'b1),
               .PH_LEN(4), .PH_MASK(4'b0010), .USE_EN(1'b0)) u_ph (
    .clk(clk), .rst_n(rst_n), .en(ph_en),
    .re_in(ph_re), .im_in(ph_im), .re_out(ph_ro), .im_out(ph_io)
  );

  cpx_addsub #(.N_IN(3), .W_IN(8), .SUB_MASK(1'b1), .PIPELINED(1'b0)) u_comb (
    .clk(clk), .rst_n(rst_n), .en(en),
    .re_in(cb_re), .im_in(cb_im), .re_out(cb_ro), .im_out(cb_io)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_edges <= 0;
    else        ph_edges <= ph_edges + 1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // main instance: signs + - - + + on ports 0..4
  function automatic int fm(int a0, int a1, int a2, int a3, int a4);
    return a0 - a1 - a2 + a3 + a4;
  endfunction

  task automatic drv_main(int r0, int r1, int r2, int r3, int r4,
                          int i0, int i1, int i2, int i3, int i4);
    re_in = {8'(r4), 8'(r3), 8'(r2), 8'(r1), 8'(r0)};
    im_in = {8'(i4), 8'(i3), 8'(i2), 8'(i1), 8'(i0)};
  endtask

  task automatic t_reset;
    chk("R9 reset re", int'(re_out), 0);
    chk("R9 reset im", int'(im_out), 0);
    chk("R9 reset phase inst", int'(ph_ro), 0);
  endtask

  task automatic t_comb;
    // R2 R10: -a + b + c, port 2 beyond the mask literal
    cb_re = {8'(7), 8'(-5), 8'(20)};
    cb_im = {8'(-1), 8'(3), 8'(-9)};
    #1;
    chk("R10 comb re", int'(cb_ro), -20 - 5 + 7);
    chk("R2 comb im", int'(cb_io), 9 + 3 - 1);
    cb_re = {8'(127), 8'(127), 8'(-128)};
    #1;
    chk("R2 comb extreme", int'(cb_ro), 128 + 127 + 127);
  endtask

  task automatic t_stream;
    int er[4];
    int ei[4];
    er[0] = fm(1, 2, 3, 4, 5);      ei[0] = fm(-7, 0, 0, 0, 0);
    er[1] = fm(10, -20, 30, -40, 50); ei[1] = fm(0, 9, 0, 0, 0);
    er[2] = fm(-3, -3, -3, -3, -3); ei[2] = fm(0, 0, 11, 0, 0);
    er[3] = fm(100, 0, -100, 1, 2); ei[3] = fm(0, 0, 0, -60, 70);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        chk("R5 R3 stream re", int'(re_out), er[i-3]);
        chk("R4 stream im", int'(im_out), ei[i-3]);
      end
      case (i)
        0: drv_main(1, 2, 3, 4, 5, -7, 0, 0, 0, 0);
        1: drv_main(10, -20, 30, -40, 50, 0, 9, 0, 0, 0);
        2: drv_main(-3, -3, -3, -3, -3, 0, 0, 11, 0, 0);
        3: drv_main(100, 0, -100, 1, 2, 0, 0, 0, -60, 70);
        default: ;
      endcase
    end
  endtask

  task automatic t_extreme;
    @(negedge clk);
    drv_main(-128, 127, 127, -128, -128, 127, -128, -128, 127, 127);
    repeat (3) @(negedge clk);
    chk("R1 min re", int'(re_out), -638);
    chk("R1 max im", int'(im_out), 637);
  endtask

  task automatic t_enable;
    @(negedge clk);
    en = 1'b1;
    drv_main(5, 6, 7, 8, 9, 1, 1, 1, 1, 1);
    repeat (4) @(negedge clk);
    chk("R7 before hold", int'(re_out), fm(5, 6, 7, 8, 9));
    en = 1'b0;
    drv_main(-50, 1, 2, 3, 4, 20, 20, 20, 20, 20);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 hold re", int'(re_out), fm(5, 6, 7, 8, 9));
      chk("R7 hold im", int'(im_out), fm(1, 1, 1, 1, 1));
    end
    en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 resume old", int'(re_out), fm(5, 6, 7, 8, 9));
    @(negedge clk);
    chk("R7 resume new", int'(re_out), fm(-50, 1, 2, 3, 4));
    chk("R7 resume new im", int'(im_out), fm(20, 20, 20, 20, 20));
  endtask

  task automatic t_clear;
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R9 clear re", int'(re_out), 0);
    chk("R9 clear im", int'(im_out), 0);
    chk("R9 clear phase inst", int'(ph_ro), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_phase;
    int caps;
    int ph;
    // R6 R8: mask 0010 loads only in phase 1; en held low and ignored
    ph_re = {8'(4), 8'(3), 8'(2), 8'(1)};
    ph_im = {8'(-4), 8'(-3), 8'(-2), 8'(-1)};
    repeat (9) @(negedge clk);
    chk("R8 settled re", int'(ph_ro), 10);
    chk("R6 settled im", int'(ph_io), -10);
    ph_re = {8'(40), 8'(30), 8'(20), 8'(10)};
    ph_im = {8'(1), 8'(1), 8'(1), 8'(1)};
    caps = 0;
    for (int k = 0; k < 12; k++) begin
      ph = int'(ph_edges % 4);
      @(posedge clk);
      @(negedge clk);
      if (ph == 1) caps++;
      chk("R6 phase re", int'(ph_ro), (caps >= 2) ? 100 : 10);
      chk("R6 phase im", int'(ph_io), (caps >= 2) ? 4 : -10);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    en    = 1'b1;
    ph_en = 1'b0;
    re_in = '0; im_in = '0;
    ph_re = '0; ph_im = '0;
    cb_re = '0; cb_im = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_comb();
    t_stream();
    t_extreme();
    t_enable();
    t_clear();
    t_phase();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule